// File: doc/BRIEF.md
# Gamepad Serial Link Responder

This block plays the device end of a select-framed, full-duplex, synchronous serial gamepad link. The host lowers an active-low select, runs a clock that idles high, and shifts command bytes in least significant bit first. Each bit the host sends is matched by one bit the device returns. The block changes its response line after each falling host clock edge, and the host samples it on the next rising edge. All host-side lines are brought into the block's own clock domain by synchronizer chains and sampled there. For this reason the host half-period must last several system clocks.

Every frame opens with the host byte 0x01 and then a command byte. In the byte slot of the command, the block returns an identity byte that tells the host the current reporting mode. The next byte is the marker 0x5A. The rest of the frame carries button and stick data or a reply to the command. The block decodes a button poll, which also carries two rumble values, and in-band commands that enter and leave a configuration mode. Inside configuration mode further commands select digital or analog reporting, remap which poll byte drives which rumble output, and report mode information. The mode and frame length used to build a frame's reply are frozen when select falls. A command therefore changes the reply only from the next frame on.

Top module: `gamepad_link_responder`

## Requirements
- R1: While select is high the response line is high. The reply in byte slot 0 of every frame is 0xFF.
- R2: The reply in byte slot 1 is 0xF3 in configuration mode, 0x73 in analog mode and 0x41 in digital mode. The reply in byte slot 2 is 0x5A.
- R3: A frame is 5 bytes in digital mode outside configuration and 9 bytes otherwise. Slots at or past that length reply 0xFF, and host bytes received in those slots have no effect.
- R4: For command 0x42, and for 0x43 sent outside configuration mode, slots 3 and 4 return the inverted button word, low byte first (a pressed button reads 0). Slots 5 to 8 return the right stick low byte, the right stick high byte, the left stick low byte and the left stick high byte. Every byte is sent least significant bit first.
- R5: In a 0x42 frame, host bytes 3 and 4 are latched onto the rumble outputs once their eighth bit has been received. The reset mapping sends byte 3 to the small motor output and byte 4 to the large one. Both outputs reset to 0.
- R6: In command 0x43, host byte 3 equal to 0x01 enters configuration mode and 0x00 leaves it. Inside configuration mode its reply slots 3 to 8 are 0x00.
- R7: Command 0x44 in configuration mode selects analog reporting when host byte 3 is 0x01 and digital reporting otherwise. Its reply slots are 0x00. Outside configuration mode it changes nothing.
- R8: Command 0x4D in configuration mode replies 0xFF in slots 3 to 8. Host byte 3 and host byte 4 set the motor for poll byte 3 and poll byte 4: value 0x00 means the small motor, 0x01 the large motor, and any other value no motor.
- R9: Command 0x45 in configuration mode replies 0x03, 0x02, mode flag, 0x02, 0x01, 0x00 in slots 3 to 8. The mode flag is 0x01 in analog mode and 0x00 otherwise.
- R10: An unrecognised command, or 0x45 or 0x4D outside configuration mode, replies 0x00 in slots 3 onward and leaves the mode unchanged.
- R11: The mode and frame length used for a frame's reply are those in force when select fell. A mode change made inside a frame shows only from the next frame.
- R12: Raising select in the middle of a frame aborts it. A byte that is not complete has no effect, and the next frame starts again at byte slot 0, bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Host select, active low |
| sck | input | 1 | Host serial clock, idles high |
| cmd | input | 1 | Host command data, least significant bit first |
| rsp | output | 1 | Device response data, high when released |
| buttons | input | 16 | Button word, 1 = pressed |
| stick_right | input | 16 | Right stick position, low byte first on the link |
| stick_left | input | 16 | Left stick position, low byte first on the link |
| rumble_small | output | 8 | Latched small motor request |
| rumble_large | output | 8 | Latched large motor request |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a four-bit slot counter, frames of 5 and 9 bytes and two mappable rumble slots. Its host half-period is eight system clocks, which leaves room for the synchronizer delay before each sample. With these values the bench can send 9-byte frames to a device in digital mode and so reach the slots past the short frame length. It can also walk the block from digital through configuration into analog reporting, and it can swap the motor mapping and then watch the poll bytes land on the opposite outputs.

// File: rtl/gpl_pkg.sv
// Package: shared constants and types for the gamepad link responder.
// Assumes byte values are fixed by the link; nothing here is tunable.
package gpl_pkg;
    localparam logic [7:0] ID_DIGITAL = 8'h41;
    localparam logic [7:0] ID_ANALOG  = 8'h73;
    localparam logic [7:0] ID_CONFIG  = 8'hF3;
    localparam logic [7:0] MARKER     = 8'h5A;
    localparam logic [7:0] IDLE_BYTE  = 8'hFF;

    localparam logic [7:0] OP_POLL    = 8'h42;
    localparam logic [7:0] OP_CFG     = 8'h43;
    localparam logic [7:0] OP_MODE    = 8'h44;
    localparam logic [7:0] OP_QUERY   = 8'h45;
    localparam logic [7:0] OP_MAP     = 8'h4D;

    typedef enum logic [1:0] {
        MOTOR_SMALL = 2'd0,
        MOTOR_LARGE = 2'd1,
        MOTOR_NONE  = 2'd2
    } motor_sel_t;

    typedef struct packed {
        logic cfg;
        logic analog;
    } dev_mode_t;
endpackage

// File: rtl/gpl_link_phy.sv
// Module: bit-level side of the link. Synchronizes select, clock and
// command into clk, shifts host bits in on rising host edges and drives
// the reply bit on falling host edges. Assumes the host half-period spans
// more than SYNC_STAGES + 2 system clocks.
module gpl_link_phy #(
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n_i,
    input  logic             sck_i,
    input  logic             cmd_i,
    input  logic [7:0]       tx_byte_i,
    output logic             idle_o,
    output logic             byte_done_o,
    output logic [7:0]       rx_byte_o,
    output logic [IDX_W-1:0] byte_idx_o,
    output logic [IDX_W-1:0] done_idx_o,
    output logic             rsp_o
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [SYNC_STAGES-1:0] sel_sr, sck_sr, cmd_sr;
    logic                   sck_prev;
    logic [2:0]             bit_cnt;
    logic                   sel_s, sck_s, cmd_s, sck_fall, sck_rise;

    assign sel_s    = sel_sr[SYNC_STAGES-1];
    assign sck_s    = sck_sr[SYNC_STAGES-1];
    assign cmd_s    = cmd_sr[SYNC_STAGES-1];
    assign sck_fall = sck_prev & ~sck_s;
    assign sck_rise = ~sck_prev & sck_s;
    assign idle_o   = sel_s;

    // Synchronizer chains and previous clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_sr   <= '1;
            sck_sr   <= '1;
            cmd_sr   <= '1;
            sck_prev <= 1'b1;
        end else begin
            sel_sr   <= {sel_sr[SYNC_STAGES-2:0], sel_n_i};
            sck_sr   <= {sck_sr[SYNC_STAGES-2:0], sck_i};
            cmd_sr   <= {cmd_sr[SYNC_STAGES-2:0], cmd_i};
            sck_prev <= sck_s;
        end
    end

    // Bit and byte sequencing, receive shift and reply bit drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            byte_idx_o  <= '0;
            done_idx_o  <= '0;
            byte_done_o <= 1'b0;
            rx_byte_o   <= '0;
            rsp_o       <= 1'b1;
        end else if (sel_s) begin
            bit_cnt     <= '0;
            byte_idx_o  <= '0;
            byte_done_o <= 1'b0;
            rsp_o       <= 1'b1;
        end else begin
            byte_done_o <= 1'b0;
            if (sck_fall) rsp_o <= tx_byte_i[bit_cnt];
            if (sck_rise) begin
                rx_byte_o <= {cmd_s, rx_byte_o[7:1]};
                bit_cnt   <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_done_o <= 1'b1;
                    done_idx_o  <= byte_idx_o;
                    if (byte_idx_o != IDX_MAX) byte_idx_o <= byte_idx_o + 1'b1;
                end
            end
        end
    end

    // R1
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s && $past(sel_s)) |-> rsp_o);

    // R12
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_s) |=> (byte_idx_o == '0 && bit_cnt == 3'd0));
endmodule

// File: rtl/gpl_responder.sv
// Module: byte-level command decoder. Holds the live and frame-frozen
// modes, builds the reply byte for the current slot and applies each
// completed host byte. Assumes slot indices come from gpl_link_phy.
module gpl_responder
    import gpl_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int SHORT_LEN = 5,
    parameter int LONG_LEN  = 9,
    parameter int MAP_SLOTS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_i,
    input  logic             byte_done_i,
    input  logic [7:0]       rx_byte_i,
    input  logic [IDX_W-1:0] byte_idx_i,
    input  logic [IDX_W-1:0] done_idx_i,
    input  logic [15:0]      buttons_i,
    input  logic [15:0]      stick_r_i,
    input  logic [15:0]      stick_l_i,
    output logic [7:0]       tx_byte_o,
    output logic [7:0]       rumble_small_o,
    output logic [7:0]       rumble_large_o
);
    localparam logic [IDX_W-1:0] LEN_S = IDX_W'(SHORT_LEN);
    localparam logic [IDX_W-1:0] LEN_L = IDX_W'(LONG_LEN);
    localparam logic [IDX_W-1:0] FIRST = IDX_W'(3);

    dev_mode_t        live, snap;
    logic [7:0]       cmd_q;
    motor_sel_t       map_q [MAP_SLOTS];
    logic [IDX_W-1:0] frame_len, pos;
    logic [7:0]       poll_b, query_b;
    logic             in_frame;

    assign frame_len = (snap.cfg || snap.analog) ? LEN_L : LEN_S;
    assign in_frame  = done_idx_i < frame_len;
    assign pos       = byte_idx_i - FIRST;

    // Poll and query payload bytes for the current slot.
    always_comb begin
        poll_b  = 8'h00;
        query_b = 8'h00;
        case (pos)
            IDX_W'(0): begin poll_b = ~buttons_i[7:0];  query_b = 8'h03; end
            IDX_W'(1): begin poll_b = ~buttons_i[15:8]; query_b = 8'h02; end
            IDX_W'(2): begin poll_b = stick_r_i[7:0];   query_b = {7'd0, snap.analog}; end
            IDX_W'(3): begin poll_b = stick_r_i[15:8];  query_b = 8'h02; end
            IDX_W'(4): begin poll_b = stick_l_i[7:0];   query_b = 8'h01; end
            IDX_W'(5): begin poll_b = stick_l_i[15:8];  query_b = 8'h00; end
            default: ;
        endcase
    end

    // Reply byte for the slot now being shifted out.
    always_comb begin
        if (byte_idx_i >= frame_len) tx_byte_o = IDLE_BYTE;
        else if (byte_idx_i == IDX_W'(0)) tx_byte_o = IDLE_BYTE;
        else if (byte_idx_i == IDX_W'(1))
            tx_byte_o = snap.cfg ? ID_CONFIG : (snap.analog ? ID_ANALOG : ID_DIGITAL);
        else if (byte_idx_i == IDX_W'(2)) tx_byte_o = MARKER;
        else begin
            case (cmd_q)
                OP_POLL:  tx_byte_o = poll_b;
                OP_CFG:   tx_byte_o = snap.cfg ? 8'h00 : poll_b;
                OP_MAP:   tx_byte_o = snap.cfg ? IDLE_BYTE : 8'h00;
                OP_QUERY: tx_byte_o = snap.cfg ? query_b : 8'h00;
                default:  tx_byte_o = 8'h00;
            endcase
        end
    end

    // Mode, mapping, command and rumble updates on completed host bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live           <= '0;
            snap           <= '0;
            cmd_q          <= '0;
            rumble_small_o <= '0;
            rumble_large_o <= '0;
            for (int s = 0; s < MAP_SLOTS; s++)
                map_q[s] <= (s == 0) ? MOTOR_SMALL : (s == 1) ? MOTOR_LARGE : MOTOR_NONE;
        end else begin
            if (idle_i) begin
                snap  <= live;
                cmd_q <= '0;
            end
            if (byte_done_i && in_frame) begin
                if (done_idx_i == IDX_W'(1)) cmd_q <= rx_byte_i;
                if (cmd_q == OP_CFG && done_idx_i == FIRST) begin
                    if (rx_byte_i == 8'h01) live.cfg <= 1'b1;
                    else if (rx_byte_i == 8'h00) live.cfg <= 1'b0;
                end
                if (cmd_q == OP_MODE && snap.cfg && done_idx_i == FIRST)
                    live.analog <= (rx_byte_i == 8'h01);
                for (int s = 0; s < MAP_SLOTS; s++) begin
                    if (done_idx_i == FIRST + IDX_W'(s)) begin
                        if (cmd_q == OP_POLL) begin
                            if (map_q[s] == MOTOR_SMALL) rumble_small_o <= rx_byte_i;
                            if (map_q[s] == MOTOR_LARGE) rumble_large_o <= rx_byte_i;
                        end
                        if (cmd_q == OP_MAP && snap.cfg)
                            map_q[s] <= (rx_byte_i == 8'h00) ? MOTOR_SMALL :
                                        (rx_byte_i == 8'h01) ? MOTOR_LARGE : MOTOR_NONE;
                    end
                end
            end
        end
    end

    // R11
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_i && $past(!idle_i)) |-> $stable(snap));

    // R7
    analog_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(live.analog) |-> $past(snap.cfg));

    // R5
    rumble_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rumble_small_o) |-> $past(byte_done_i));

    // R5
    rumble_large_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rumble_large_o) |-> $past(byte_done_i));
endmodule

// File: rtl/gamepad_link_responder.sv
// Module: top of the gamepad link responder. Joins the bit-level link
// side to the command decoder. Assumes one system clock domain and a host
// clock slow enough to be oversampled.
module gamepad_link_responder #(
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = 4,
    parameter int SHORT_LEN   = 5,
    parameter int LONG_LEN    = 9,
    parameter int MAP_SLOTS   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_n,
    input  logic        sck,
    input  logic        cmd,
    output logic        rsp,
    input  logic [15:0] buttons,
    input  logic [15:0] stick_right,
    input  logic [15:0] stick_left,
    output logic [7:0]  rumble_small,
    output logic [7:0]  rumble_large
);
    logic             idle, byte_done;
    logic [7:0]       rx_byte, tx_byte;
    logic [IDX_W-1:0] byte_idx, done_idx;

    gpl_link_phy #(.SYNC_STAGES(SYNC_STAGES), .IDX_W(IDX_W)) u_phy (
        .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sck_i(sck), .cmd_i(cmd),
        .tx_byte_i(tx_byte), .idle_o(idle), .byte_done_o(byte_done),
        .rx_byte_o(rx_byte), .byte_idx_o(byte_idx), .done_idx_o(done_idx),
        .rsp_o(rsp)
    );

    gpl_responder #(.IDX_W(IDX_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN),
                    .MAP_SLOTS(MAP_SLOTS)) u_resp (
        .clk(clk), .rst_n(rst_n), .idle_i(idle), .byte_done_i(byte_done),
        .rx_byte_i(rx_byte), .byte_idx_i(byte_idx), .done_idx_i(done_idx),
        .buttons_i(buttons), .stick_r_i(stick_right), .stick_l_i(stick_left),
        .tx_byte_o(tx_byte), .rumble_small_o(rumble_small),
        .rumble_large_o(rumble_large)
    );
endmodule

// File: tb/gamepad_link_responder_tb.sv
module gamepad_link_responder_tb;
    localparam int CLK_NS = 4;
    localparam int HALF   = 8;
    localparam int GAP    = 16;
    localparam int ROWS   = 15;

    logic clk = 1'b0, rst_n = 1'b0, sel_n = 1'b1, sck = 1'b1, cmd = 1'b1;
    logic rsp;
    logic [15:0] buttons = 16'h0005, stick_right = 16'h2010, stick_left = 16'h4030;
    logic [7:0]  rumble_small, rumble_large;
    logic [7:0]  htx [9];
    logic [7:0]  hrx [9];
    int errors = 0, checks = 0;
    bit finished = 0;
    string row_req [ROWS];

    // Row: length, host bytes 0..8, expected replies 0..8, small, large.
    localparam logic [7:0] TBL [ROWS][21] = '{
        '{5, 8'h01,8'h42,0,8'h11,8'h22,0,0,0,0, 8'hFF,8'h41,8'h5A,8'hFA,8'hFF,0,0,0,0, 8'h11,8'h22},
        '{9, 8'h01,8'h42,0,8'h33,8'h44,0,0,0,0, 8'hFF,8'h41,8'h5A,8'hFA,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF, 8'h33,8'h44},
        '{5, 8'h01,8'h45,0,0,0,0,0,0,0, 8'hFF,8'h41,8'h5A,0,0,0,0,0,0, 8'h33,8'h44},
        '{5, 8'h01,8'h44,0,8'h01,8'h03,0,0,0,0, 8'hFF,8'h41,8'h5A,0,0,0,0,0,0, 8'h33,8'h44},
        '{5, 8'h01,8'h42,0,0,0,0,0,0,0, 8'hFF,8'h41,8'h5A,8'hFA,8'hFF,0,0,0,0, 0,0},
        '{5, 8'h01,8'h43,0,8'h01,0,0,0,0,0, 8'hFF,8'h41,8'h5A,8'hFA,8'hFF,0,0,0,0, 0,0},
        '{9, 8'h01,8'h42,0,0,0,0,0,0,0, 8'hFF,8'hF3,8'h5A,8'hFA,8'hFF,8'h10,8'h20,8'h30,8'h40, 0,0},
        '{9, 8'h01,8'h45,0,8'h5A,8'h5A,8'h5A,8'h5A,8'h5A,8'h5A, 8'hFF,8'hF3,8'h5A,8'h03,8'h02,8'h00,8'h02,8'h01,8'h00, 0,0},
        '{9, 8'h01,8'h44,0,8'h01,8'h03,0,0,0,0, 8'hFF,8'hF3,8'h5A,0,0,0,0,0,0, 0,0},
        '{9, 8'h01,8'h45,0,8'h5A,8'h5A,8'h5A,8'h5A,8'h5A,8'h5A, 8'hFF,8'hF3,8'h5A,8'h03,8'h02,8'h01,8'h02,8'h01,8'h00, 0,0},
        '{9, 8'h01,8'h4D,0,8'h01,8'h00,8'hFF,8'hFF,8'hFF,8'hFF, 8'hFF,8'hF3,8'h5A,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF,8'hFF, 0,0},
        '{9, 8'h01,8'h47,0,0,0,0,0,0,0, 8'hFF,8'hF3,8'h5A,0,0,0,0,0,0, 0,0},
        '{9, 8'h01,8'h43,0,0,0,0,0,0,0, 8'hFF,8'hF3,8'h5A,0,0,0,0,0,0, 0,0},
        '{9, 8'h01,8'h42,0,8'h55,8'h66,0,0,0,0, 8'hFF,8'h73,8'h5A,8'hFA,8'hFF,8'h10,8'h20,8'h30,8'h40, 8'h66,8'h55},
        '{5, 8'h01,8'h42,0,8'h77,8'h88,0,0,0,0, 8'hFF,8'h73,8'h5A,8'hFA,8'hFF,0,0,0,0, 8'h88,8'h77}
    };

    gamepad_link_responder u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .cmd(cmd), .rsp(rsp),
        .buttons(buttons), .stick_right(stick_right), .stick_left(stick_left),
        .rumble_small(rumble_small), .rumble_large(rumble_large)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(input string tag, input string what, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 0; i < n; i++) begin
            sck = 1'b0; cmd = tx[i];
            #(HALF*CLK_NS);
            rx[i] = rsp;
            sck = 1'b1;
            #(HALF*CLK_NS);
        end
    endtask

    task automatic frame(input int n);
        sel_n = 1'b0;
        #(GAP*CLK_NS);
        for (int k = 0; k < n; k++) bits(htx[k], 8, hrx[k]);
        #(GAP*CLK_NS);
        sel_n = 1'b1; cmd = 1'b1;
        #(GAP*CLK_NS);
    endtask

    initial begin
        logic [7:0] junk;
        row_req = '{"R4 R5", "R3", "R10", "R7", "R7 R10", "R6 R11", "R2 R11",
                    "R9", "R7", "R9", "R8", "R10", "R6", "R2 R5 R8", "R4 R8"};
        #1;
        #(5*CLK_NS) rst_n = 1'b1;
        #(4*CLK_NS);
        // Reset state: line released, rumble cleared.
        check("R1", "idle line after reset", {7'd0, rsp}, 8'h01);
        check("R5", "small rumble after reset", rumble_small, 8'h00);
        check("R5", "large rumble after reset", rumble_large, 8'h00);

        for (int r = 0; r < ROWS; r++) begin
            for (int k = 0; k < 9; k++) htx[k] = TBL[r][1+k];
            frame(int'(TBL[r][0]));
            for (int k = 0; k < int'(TBL[r][0]); k++)
                check(row_req[r], $sformatf("row %0d slot %0d", r, k), hrx[k], TBL[r][10+k]);
            check(row_req[r], $sformatf("row %0d small rumble", r), rumble_small, TBL[r][19]);
            check(row_req[r], $sformatf("row %0d large rumble", r), rumble_large, TBL[r][20]);
            check("R1", $sformatf("row %0d idle line", r), {7'd0, rsp}, 8'h01);
        end

        // R12: abort a configuration-enter frame part way into host byte 3.
        sel_n = 1'b0;
        #(GAP*CLK_NS);
        bits(8'h01, 8, junk);
        bits(8'h43, 8, junk);
        bits(8'h00, 8, junk);
        bits(8'h01, 3, junk);
        sel_n = 1'b1; cmd = 1'b1;
        #(GAP*CLK_NS);
        check("R12", "line released after abort", {7'd0, rsp}, 8'h01);
        htx = '{8'h01, 8'h42, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        frame(9);
        check("R12", "slot 0 after abort", hrx[0], 8'hFF);
        check("R12", "mode unchanged after abort", hrx[1], 8'h73);
        check("R12", "marker after abort", hrx[2], 8'h5A);
        check("R4", "right stick low after abort", hrx[5], 8'h10);

        // R4: new button and stick pattern with analog reporting.
        buttons = 16'h8100; stick_right = 16'hC3A5; stick_left = 16'h0FF0;
        #(GAP*CLK_NS);
        frame(9);
        check("R4", "buttons low", hrx[3], 8'hFF);
        check("R4", "buttons high", hrx[4], 8'h7E);
        check("R4", "right stick high", hrx[6], 8'hC3);
        check("R4", "left stick low", hrx[7], 8'hF0);
        check("R4", "left stick high", hrx[8], 8'h0F);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000*CLK_NS);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule